// File: doc/BRIEF.md
# Byte Array Program and Erase Sequencer

This block carries out byte program, single-sector erase and whole-array erase on a byte-addressed storage array split into eight equal sectors. The sector size is a parameter, so simulation can use a small array. Commands arrive from an upstream command decoder as a one-cycle pulse with an operation code, an address and a data byte. Host reads use a read strobe and the same address bus. The result appears on a registered read bus one cycle after the strobe.

While an operation runs, a read returns a status word instead of array data. Bit 7 is the complement of the final bit 7 of the data being written, so software can poll it until it matches. Bit 6 flips on every status read. Bit 5 reports that the time limit was exceeded. Real pulse widths are replaced by cycle counts: a program takes `PROG_CYC` cycles, a failing program runs to `LIMIT_CYC` cycles, and erase has a settle interval of `WAIT_CYC` cycles. Erase walks the target bytes one per cycle. It first writes 00h to each of them, waits, and then writes FFh to each of them. An erase can be suspended so that the host can read any byte and program bytes outside the sectors being erased. A resume command continues the erase. Per-sector protection inputs block all changes to their sectors.

Top module: `pe_engine`

## Requirements
- R1: A program command (op code 1) to an unprotected sector stores the old byte ANDed with the new data. When no bit would have to go from 0 to 1, `busy` is high for exactly `PROG_CYC` cycles after the accepting edge.
- R2: A read accepted while `busy` is high returns a status word with bits 4..0 equal to 0. Bit 7 is the inverse of bit 7 of the program data during a program, and bit 7 is 0 during an erase.
- R3: Bit 6 of the status word takes opposite values on two consecutive status reads.
- R4: A program that asks for a 0-to-1 change keeps `busy` high. After `LIMIT_CYC` cycles, status bit 5 reads 1. The block stays in this state until a reset command (op code 0), after which the byte reads old AND new.
- R5: Sector erase (op code 2) sets every byte of the sector named by the top three address bits to FFh and leaves the other sectors unchanged. Chip erase (op code 3) sets every unprotected sector to FFh.
- R6: Erase writes 00h to each target byte in ascending address order, one byte per cycle starting on the edge after acceptance, before any byte is set to FFh.
- R7: When the `prot` bit of a sector is 1, a program or sector erase aimed at that sector is not accepted (`busy` stays low) and changes nothing. Chip erase leaves protected sectors intact. `prot` is held steady while an operation runs.
- R8: Suspend (op code 4) during an erase drops `busy`. While suspended, reads return array data, and a program to an unprotected sector outside the erase set runs and then returns to the suspended state. A program into the erase set is ignored. Resume (op code 5) finishes the erase.
- R9: After an operation completes without error, `busy` falls and reads return array data with no further command.
- R10: While `sel` is low, commands and reads are ignored and `rdata` holds its value. An operation already running still completes.
- R11: While a program is running, including its final cycle, any command is ignored.
- R12: After reset, `busy` is low and `rdata` is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Block selected; gates commands and reads |
| cmd_valid | input | 1 | One-cycle command pulse |
| cmd_op | input | 3 | Operation code: 0 reset, 1 program, 2 sector erase, 3 chip erase, 4 suspend, 5 resume |
| addr | input | AW | Byte address; top three bits pick the sector |
| wdata | input | 8 | Program data |
| rd_en | input | 1 | Read strobe |
| prot | input | 8 | Per-sector protection, bit n guards sector n |
| rdata | output | 8 | Registered read data or status word |
| busy | output | 1 | Operation in progress or time-limit state |

## Verification
Two events can land on the final cycle of a program: the array write, and a read or a new command. The bench counts cycles from the accepting edge. It issues back-to-back reads and expects exactly `PROG_CYC` status words, the last of which coincides with the write, followed by the stored byte. In a separate run it places a second program command on that final edge and expects the command to leave its target byte at FFh and `busy` low on the next cycle.

// File: rtl/pe_pkg.sv
`timescale 1ns/1ps
package pe_pkg;
  typedef enum logic [2:0] {
    OP_RESET  = 3'd0,
    OP_PROG   = 3'd1,
    OP_SERASE = 3'd2,
    OP_CERASE = 3'd3,
    OP_SUSP   = 3'd4,
    OP_RESUME = 3'd5
  } op_e;

  typedef enum logic [2:0] {
    ST_READ  = 3'd0,
    ST_PROG  = 3'd1,
    ST_PRE   = 3'd2,
    ST_WAIT  = 3'd3,
    ST_WIPE  = 3'd4,
    ST_SUSP  = 3'd5,
    ST_SPROG = 3'd6,
    ST_FAIL  = 3'd7
  } st_e;
endpackage

// File: rtl/pe_array.sv
`timescale 1ns/1ps
module pe_array #(
  parameter int AW = 7,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdat,
  input  logic [AW-1:0] raddr_a,
  output logic [7:0]    rdat_a,
  input  logic [AW-1:0] raddr_b,
  output logic [7:0]    rdat_b
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdat;
  end

  assign rdat_a = mem[raddr_a];
  assign rdat_b = mem[raddr_b];
endmodule

// File: rtl/pe_timer.sv
`timescale 1ns/1ps
module pe_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          clr,
  output logic [CW-1:0] cnt
);
  logic [CW-1:0] cnt_n;

  always_comb begin
    cnt_n = cnt;
    if (clr)     cnt_n = '0;
    else if (en) cnt_n = cnt + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_n;
  end
endmodule

// File: rtl/pe_status.sv
`timescale 1ns/1ps
module pe_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_fire,
  input  logic       show_stat,
  input  logic       poll_bit,
  input  logic       limit_bit,
  input  logic [7:0] arr_data,
  output logic [7:0] rdata
);
  logic       tog, tog_n;
  logic [7:0] rdata_n;

  always_comb begin
    tog_n   = tog;
    rdata_n = rdata;
    if (rd_fire) begin
      if (show_stat) begin
        rdata_n = {poll_bit, tog, limit_bit, 5'b00000};
        tog_n   = ~tog;
      end else begin
        rdata_n = arr_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog   <= 1'b0;
      rdata <= 8'h00;
    end else begin
      tog   <= tog_n;
      rdata <= rdata_n;
    end
  end
endmodule

// File: rtl/pe_engine.sv
`timescale 1ns/1ps
module pe_engine
  import pe_pkg::*;
#(
  parameter int SEC_BITS  = 4,
  parameter int PROG_CYC  = 4,
  parameter int LIMIT_CYC = 12,
  parameter int WAIT_CYC  = 6,
  localparam int SW = 3,
  localparam int AW = SW + SEC_BITS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  input  logic          rd_en,
  input  logic [7:0]    prot,
  output logic [7:0]    rdata,
  output logic          busy
);
  localparam int MAXC = (LIMIT_CYC > WAIT_CYC) ? LIMIT_CYC : WAIT_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync <= 2'b00;
    else        rsync <= {rsync[0], 1'b1};
  end
  assign rst_i = rsync[1];

  st_e           st, st_n, rs, rs_n;
  logic [AW-1:0] pa, pa_n, ptr, ptr_n, elo, elo_n, ehi, ehi_n;
  logic [7:0]    pd, pd_n, eset, eset_n;
  logic          we, tclr;
  logic [AW-1:0] wa;
  logic [7:0]    wd, old_a, arr_b;
  logic [CW-1:0] cnt;
  logic          fire, rd_fire, conflict;
  logic [SW-1:0] csec, psec;
  op_e           op;

  assign fire     = cmd_valid & sel;
  assign rd_fire  = rd_en & sel;
  assign op       = op_e'(cmd_op);
  assign csec     = addr[AW-1 -: SW];
  assign psec     = ptr[AW-1 -: SW];
  assign conflict = |(~old_a & pd);
  assign busy     = (st != ST_READ) && (st != ST_SUSP);

  pe_array #(.AW(AW)) u_array (
    .clk(clk), .we(we), .waddr(wa), .wdat(wd),
    .raddr_a(pa), .rdat_a(old_a),
    .raddr_b(addr), .rdat_b(arr_b)
  );

  pe_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_i), .en(busy), .clr(tclr), .cnt(cnt)
  );

  pe_status u_status (
    .clk(clk), .rst_n(rst_i), .rd_fire(rd_fire), .show_stat(busy),
    .poll_bit((st == ST_PROG || st == ST_SPROG || st == ST_FAIL) ? ~pd[7] : 1'b0),
    .limit_bit(st == ST_FAIL),
    .arr_data(arr_b), .rdata(rdata)
  );

  always_comb begin
    st_n   = st;
    rs_n   = rs;
    pa_n   = pa;
    pd_n   = pd;
    eset_n = eset;
    ptr_n  = ptr;
    elo_n  = elo;
    ehi_n  = ehi;
    we     = 1'b0;
    wa     = ptr;
    wd     = 8'h00;
    tclr   = 1'b0;
    case (st)
      ST_READ: begin
        if (fire) begin
          case (op)
            OP_PROG: if (!prot[csec]) begin
              pa_n = addr;
              pd_n = wdata;
              tclr = 1'b1;
              st_n = ST_PROG;
            end
            OP_SERASE: if (!prot[csec]) begin
              eset_n       = '0;
              eset_n[csec] = 1'b1;
              ptr_n        = {csec, {SEC_BITS{1'b0}}};
              elo_n        = {csec, {SEC_BITS{1'b0}}};
              ehi_n        = {csec, {SEC_BITS{1'b1}}};
              st_n         = ST_PRE;
            end
            OP_CERASE: if (~prot != 8'h00) begin
              eset_n = ~prot;
              ptr_n  = '0;
              elo_n  = '0;
              ehi_n  = '1;
              st_n   = ST_PRE;
            end
            default: ;
          endcase
        end
      end
      ST_PROG, ST_SPROG: begin
        wa = pa;
        wd = old_a & pd;
        if (!conflict && cnt == CW'(PROG_CYC - 1)) begin
          we   = 1'b1;
          st_n = (st == ST_PROG) ? ST_READ : ST_SUSP;
        end else if (conflict && cnt == CW'(LIMIT_CYC - 1)) begin
          we   = 1'b1;
          st_n = ST_FAIL;
        end
      end
      ST_PRE, ST_WIPE: begin
        if (fire && op == OP_SUSP) begin
          rs_n = st;
          st_n = ST_SUSP;
        end else begin
          we = eset[psec];
          wd = (st == ST_WIPE) ? 8'hFF : 8'h00;
          if (ptr == ehi) begin
            ptr_n = elo;
            tclr  = 1'b1;
            st_n  = (st == ST_PRE) ? ST_WAIT : ST_READ;
          end else begin
            ptr_n = ptr + AW'(1);
          end
        end
      end
      ST_WAIT: begin
        if (fire && op == OP_SUSP) begin
          rs_n = ST_WAIT;
          st_n = ST_SUSP;
        end else if (cnt == CW'(WAIT_CYC - 1)) begin
          st_n = ST_WIPE;
        end
      end
      ST_SUSP: begin
        if (fire && op == OP_RESUME) begin
          tclr = 1'b1;
          st_n = rs;
        end else if (fire && op == OP_PROG && !prot[csec] && !eset[csec]) begin
          pa_n = addr;
          pd_n = wdata;
          tclr = 1'b1;
          st_n = ST_SPROG;
        end
      end
      ST_FAIL: begin
        if (fire && op == OP_RESET) st_n = ST_READ;
      end
      default: st_n = ST_READ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      st   <= ST_READ;
      rs   <= ST_PRE;
      pa   <= '0;
      pd   <= 8'hFF;
      eset <= '0;
      ptr  <= '0;
      elo  <= '0;
      ehi  <= '0;
    end else begin
      st   <= st_n;
      rs   <= rs_n;
      pa   <= pa_n;
      pd   <= pd_n;
      eset <= eset_n;
      ptr  <= ptr_n;
      elo  <= elo_n;
      ehi  <= ehi_n;
    end
  end
endmodule

// File: rtl/pe_engine_chk.sv
`timescale 1ns/1ps
module pe_engine_chk
  import pe_pkg::*;
#(
  parameter int AW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sel,
  input logic          rd_en,
  input logic          cmd_valid,
  input logic          busy,
  input logic [7:0]    rdata,
  input logic [7:0]    prot,
  input logic          we,
  input logic [AW-1:0] waddr,
  input logic [7:0]    wdat,
  input logic [7:0]    old_a,
  input st_e           st,
  input logic [7:0]    eset
);
  logic stat_r1, stat_r2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_r1 <= 1'b0;
      stat_r2 <= 1'b0;
    end else begin
      stat_r1 <= rd_en && sel && busy;
      stat_r2 <= stat_r1;
    end
  end

  assert_idle_at_start_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !busy);

  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && sel) |=> $stable(rdata));

  assert_clear_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (we && (st == ST_PROG || st == ST_SPROG)) |-> ((wdat & ~old_a) == 8'h00));

  assert_guarded_sector_R7: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> !prot[waddr[AW-1 -: 3]]);

  assert_erase_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (we && (st == ST_PRE || st == ST_WIPE)) |-> eset[waddr[AW-1 -: 3]]);

  assert_status_low_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stat_r1 |-> rdata[4:0] == 5'b00000);

  assert_toggle_flip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_r1 && stat_r2) |-> rdata[6] != $past(rdata[6]));

  assert_limit_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_r1 && rdata[5] && !$past(cmd_valid && sel)) |-> busy);
endmodule

bind pe_engine pe_engine_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .rd_en(rd_en), .cmd_valid(cmd_valid),
  .busy(busy), .rdata(rdata), .prot(prot), .we(we), .waddr(wa), .wdat(wd),
  .old_a(old_a), .st(st), .eset(eset)
);

// File: tb/test_pe_engine.sv
`timescale 1ns/1ps
module test_pe_engine;
  import pe_pkg::*;
  localparam int SB = 4;
  localparam int AW = 3 + SB;
  localparam int PC = 4;
  localparam int LC = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sel = 1'b1;
  logic          cmd_valid = 1'b0;
  logic [2:0]    cmd_op = 3'd0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    wdata = 8'h00;
  logic          rd_en = 1'b0;
  logic [7:0]    prot = 8'h00;
  logic [7:0]    rdata;
  logic          busy;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  pe_engine #(.SEC_BITS(SB), .PROG_CYC(PC), .LIMIT_CYC(LC), .WAIT_CYC(6)) i_pe_engine (
    .clk(clk), .rst_n(rst_n), .sel(sel), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .addr(addr), .wdata(wdata), .rd_en(rd_en), .prot(prot), .rdata(rdata), .busy(busy)
  );

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
    end
  endtask

  task automatic chk8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk1(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b", tag, act, exp);
    end
  endtask

  // called at a falling edge; the next rising edge samples the command
  task automatic do_cmd(input op_e op, input logic [AW-1:0] a, input logic [7:0] d);
    cmd_valid = 1'b1; cmd_op = op; addr = a; wdata = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic do_rd(input logic [AW-1:0] a, output logic [7:0] q);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    q = rdata;
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    while (busy && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk1({tag, " completion"}, busy, 1'b0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk1("R12 busy after reset", busy, 1'b0);
    chk8("R12 rdata after reset", rdata, 8'h00);
  endtask

  task automatic t_init();
    logic [7:0] q;
    prot = 8'h00;
    do_cmd(OP_CERASE, '0, 8'h00);
    chk1("R5 chip erase busy", busy, 1'b1);
    wait_done("R5");
    do_rd(7'h00, q); chk8("R5 chip erase first byte", q, 8'hFF);
    do_rd(7'h7F, q); chk8("R5 chip erase last byte", q, 8'hFF);
  endtask

  task automatic t_program();
    logic [7:0] q, prev;
    prev = 8'h00;
    do_cmd(OP_PROG, 7'h05, 8'h5A);
    chk1("R1 busy after accept", busy, 1'b1);
    for (int i = 0; i < PC; i++) begin
      do_rd(7'h05, q);
      chk1("R2 poll bit during program", q[7], 1'b1);
      chk8("R2 low status bits", {3'b000, q[4:0]}, 8'h00);
      chk1("R4 limit bit clear on good program", q[5], 1'b0);
      if (i > 0) chk1("R3 toggle flips", q[6], ~prev[6]);
      prev = q;
    end
    chk1("R1 busy exactly PROG_CYC cycles", busy, 1'b0);
    do_rd(7'h05, q);
    chk8("R9 data after program", q, 8'h5A);
    do_cmd(OP_PROG, 7'h05, 8'h50);
    wait_done("R1");
    do_rd(7'h05, q);
    chk8("R1 clearing program", q, 8'h50);
  endtask

  task automatic t_ignore();
    logic [7:0] q;
    do_cmd(OP_PROG, 7'h06, 8'h0F);
    do_cmd(OP_SERASE, 7'h06, 8'h00);
    repeat (PC - 2) @(negedge clk);
    do_cmd(OP_PROG, 7'h07, 8'h00);
    chk1("R11 command on final edge not started", busy, 1'b0);
    do_rd(7'h06, q); chk8("R11 first program stored", q, 8'h0F);
    do_rd(7'h07, q); chk8("R11 ignored program target", q, 8'hFF);
  endtask

  task automatic t_fail();
    logic [7:0] q;
    do_cmd(OP_PROG, 7'h10, 8'h3C);
    wait_done("R4");
    do_cmd(OP_PROG, 7'h10, 8'hC3);
    do_rd(7'h10, q);
    chk1("R4 limit bit not yet set", q[5], 1'b0);
    chk1("R2 poll bit inverted", q[7], 1'b0);
    repeat (LC + 2) @(negedge clk);
    chk1("R4 still busy past limit", busy, 1'b1);
    do_rd(7'h10, q);
    chk1("R4 limit bit set", q[5], 1'b1);
    repeat (3) @(negedge clk);
    chk1("R4 stays in status state", busy, 1'b1);
    do_cmd(OP_RESET, '0, 8'h00);
    chk1("R4 reset command leaves status state", busy, 1'b0);
    do_rd(7'h10, q);
    chk8("R4 byte after failed program", q, 8'h00);
  endtask

  task automatic t_protect();
    logic [7:0] q;
    do_cmd(OP_PROG, 7'h21, 8'h11);
    wait_done("R7");
    prot = 8'h04;
    do_cmd(OP_PROG, 7'h22, 8'h00);
    chk1("R7 program to guarded sector refused", busy, 1'b0);
    do_cmd(OP_SERASE, 7'h20, 8'h00);
    chk1("R7 erase of guarded sector refused", busy, 1'b0);
    do_rd(7'h22, q); chk8("R7 guarded byte unchanged", q, 8'hFF);
    do_cmd(OP_CERASE, '0, 8'h00);
    wait_done("R7");
    do_rd(7'h21, q); chk8("R7 chip erase skips guarded", q, 8'h11);
    do_rd(7'h05, q); chk8("R5 chip erase clears open sector", q, 8'hFF);
    prot = 8'h00;
  endtask

  task automatic t_serase();
    logic [7:0] q;
    do_cmd(OP_PROG, 7'h30, 8'h00); wait_done("R5");
    do_cmd(OP_PROG, 7'h40, 8'h12); wait_done("R5");
    do_cmd(OP_SERASE, 7'h35, 8'h00);
    do_rd(7'h30, q);
    chk1("R2 poll bit zero during erase", q[7], 1'b0);
    chk8("R2 erase status low bits", {3'b000, q[4:0]}, 8'h00);
    wait_done("R5");
    do_rd(7'h30, q); chk8("R5 sector first byte", q, 8'hFF);
    do_rd(7'h40, q); chk8("R5 neighbour sector kept", q, 8'h12);
  endtask

  task automatic t_suspend();
    logic [7:0] q;
    do_cmd(OP_PROG, 7'h4F, 8'h77); wait_done("R8");
    do_cmd(OP_SERASE, 7'h40, 8'h00);
    repeat (2) @(negedge clk);
    do_cmd(OP_SUSP, '0, 8'h00);
    chk1("R8 busy low in suspend", busy, 1'b0);
    do_rd(7'h40, q); chk8("R6 first byte preprogrammed", q, 8'h00);
    do_rd(7'h41, q); chk8("R6 second byte preprogrammed", q, 8'h00);
    do_rd(7'h42, q); chk8("R6 third byte not reached", q, 8'hFF);
    do_rd(7'h4F, q); chk8("R6 last byte not reached", q, 8'h77);
    do_cmd(OP_PROG, 7'h50, 8'h66);
    chk1("R8 program in suspend accepted", busy, 1'b1);
    wait_done("R8");
    do_rd(7'h50, q); chk8("R8 program in suspend stored", q, 8'h66);
    do_cmd(OP_PROG, 7'h43, 8'h00);
    chk1("R8 program into erase set refused", busy, 1'b0);
    do_rd(7'h43, q); chk8("R8 erase-set byte untouched", q, 8'hFF);
    do_cmd(OP_RESUME, '0, 8'h00);
    chk1("R8 resume busy", busy, 1'b1);
    wait_done("R8");
    do_rd(7'h40, q); chk8("R8 resumed erase first", q, 8'hFF);
    do_rd(7'h4F, q); chk8("R8 resumed erase last", q, 8'hFF);
    do_rd(7'h50, q); chk8("R8 other sector kept", q, 8'h66);
  endtask

  task automatic t_deselect();
    logic [7:0] q, q0;
    do_rd(7'h21, q0);
    do_cmd(OP_PROG, 7'h60, 8'h81);
    sel = 1'b0;
    do_rd(7'h05, q);
    chk8("R10 rdata held while deselected", q, q0);
    do_cmd(OP_PROG, 7'h61, 8'h00);
    repeat (PC + 2) @(negedge clk);
    chk1("R10 operation completes deselected", busy, 1'b0);
    sel = 1'b1;
    do_rd(7'h60, q); chk8("R10 program finished", q, 8'h81);
    do_rd(7'h61, q); chk8("R10 deselected command ignored", q, 8'hFF);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual running expected done");
      summary();
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_init();
    t_program();
    t_ignore();
    t_fail();
    t_protect();
    t_serase();
    t_suspend();
    t_deselect();
    summary();
    $finish;
  end
endmodule